// File: doc/BRIEF.md
# Scrolling Framebuffer Scanout Address Generator

This block sits between a video timing generator and a byte-wide video RAM. It turns a 1280x720 raster into a coarser picture. Each framebuffer byte covers four neighbouring output pixels, and each framebuffer line is shown a programmable number of times. For every active output pixel it presents a 17-bit read address. It also turns the byte that comes back from the RAM into one bit each of red, green and blue.

The address of the top-left pixel comes from a 16-bit start register. Each new framebuffer line adds a 16-bit line stride to the first address of the previous line. The stride does not depend on the visible width, so software scrolls over a playfield wider and taller than the screen by changing only the start address. The start, stride and repeat values are captured at start of frame, so a CPU update in the middle of a frame takes effect on the next frame only. The pixel clock is an integer multiple of the CPU clock and in phase with it, so the register inputs need no synchronisers.

Top module: `scanout_addr_gen`

## Requirements
- R1: After reset `rd_addr_o` is 0 and all three colour outputs are 0.
- R2: Within a displayed line, the address shown during the k-th active cycle after the start-of-line pulse (k counted from 0) is the line's first address plus floor(k/4). Cycles with `active_i` low do not advance k and leave `rd_addr_o` unchanged.
- R3: The first line after a start-of-frame pulse begins at `start_addr_i`, zero-extended to 17 bits, as it stood in the start-of-frame cycle.
- R4: Each framebuffer line is shown on (R+1) consecutive output lines, where R is the `line_rpt_i` value captured at start of frame. R=3 shows each line four times and R=0 shows each line once.
- R5: Moving on to the next framebuffer line adds the captured `line_ofs_i` to the previous first address. All address arithmetic wraps modulo 2^17.
- R6: Changes to `start_addr_i`, `line_ofs_i` or `line_rpt_i` between two start-of-frame pulses have no effect on the addresses of the current frame.
- R7: When the start-of-frame and start-of-line pulses fall in the same cycle, that line is the first line of the new frame and starts at the new start address.
- R8: The colour outputs have one cycle of read latency. If `active_i` was high in the previous cycle, red is bit 2, green is bit 1 and blue is bit 0 of `pix_byte_i`. Otherwise all three outputs are 0.
- R9: A start-of-line pulse restarts the four-pixel grouping, even when the previous line ended partway through a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| active_i | input | 1 | High during visible pixels |
| sof_i | input | 1 | Start-of-frame pulse, one cycle |
| sol_i | input | 1 | Start-of-line pulse, one cycle, before the line's active pixels |
| start_addr_i | input | 16 | Address of the top-left framebuffer byte |
| line_ofs_i | input | 16 | Byte stride between framebuffer lines |
| line_rpt_i | input | 8 | Extra repetitions of each framebuffer line |
| pix_byte_i | input | 8 | Byte returned by video RAM, one cycle after its address |
| rd_addr_o | output | 17 | Video RAM read address |
| red_o | output | 1 | Red colour bit |
| green_o | output | 1 | Green colour bit |
| blue_o | output | 1 | Blue colour bit |

## Verification
Two events can fall in the same cycle: a frame restart that reloads the line base, and a line start that would otherwise advance the line base or repeat the current line. The bench provokes this with a frame that opens with both pulses together, after a frame that was left partway through a repeat group. It judges the result by comparing every active-cycle address of the following lines with a model computed from the captured start, stride and repeat values. The bench also changes the register inputs at random in the middle of frames and ends lines partway through a pixel group, so capture at start of frame and the horizontal restart are checked in the same runs.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned ADDR_W = 17;
  localparam int unsigned REG_W  = 16;
  typedef logic [ADDR_W-1:0] vaddr_t;
endpackage

// File: rtl/scan_vline.sv
// Vertical side: line base, repeat counter and frame-start capture.
module scan_vline
  import scan_pkg::*;
#(
  parameter int unsigned RPT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             sol_i,
  input  logic [REG_W-1:0] start_i,
  input  logic [REG_W-1:0] ofs_i,
  input  logic [RPT_W-1:0] rpt_i,
  output vaddr_t           load_o
);
  localparam int unsigned PAD_W = ADDR_W - REG_W;

  vaddr_t           base_q, ofs_q, adv;
  logic [RPT_W-1:0] cnt_q, rpt_q;
  logic             first_q;
  logic             wrap_rpt;

  assign adv      = base_q + ofs_q;
  assign wrap_rpt = (cnt_q == rpt_q);

  always_comb begin
    load_o = base_q;
    if (sof_i)                      load_o = {{PAD_W{1'b0}}, start_i};
    else if (!first_q && wrap_rpt)  load_o = adv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      ofs_q   <= '0;
      rpt_q   <= '0;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (sof_i) begin
      base_q  <= {{PAD_W{1'b0}}, start_i};
      ofs_q   <= {{PAD_W{1'b0}}, ofs_i};
      rpt_q   <= rpt_i;
      cnt_q   <= '0;
      first_q <= !sol_i;  // coincident line start consumes the first line
    end else if (sol_i) begin
      if (first_q) begin
        first_q <= 1'b0;
      end else if (wrap_rpt) begin
        base_q <= adv;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= rpt_q);

  a_r3_sof_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> base_q == {{PAD_W{1'b0}}, $past(start_i)});

  a_r6_hold_ofs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(ofs_q) && $stable(rpt_q));

  a_r5_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sol_i && !sof_i && !first_q && wrap_rpt) |=>
      base_q == $past(base_q) + $past(ofs_q));
endmodule

// File: rtl/scan_hcount.sv
// Horizontal side: pixel repeat phase and per-line read address.
module scan_hcount
  import scan_pkg::*;
#(
  parameter int unsigned H_REP = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   active_i,
  input  logic   sol_i,
  input  vaddr_t load_i,
  output vaddr_t addr_o
);
  localparam int unsigned PH_W = (H_REP > 1) ? $clog2(H_REP) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(H_REP - 1);

  logic [PH_W-1:0] ph_q;
  vaddr_t          addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      addr_q <= '0;
    end else if (sol_i) begin
      ph_q   <= '0;
      addr_q <= load_i;
    end else if (active_i) begin
      if (ph_q == PH_LAST) begin
        ph_q   <= '0;
        addr_q <= addr_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign addr_o = addr_q;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !sol_i) |=>
      (addr_q == $past(addr_q)) || (addr_q == $past(addr_q) + 1'b1));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !sol_i) |=> $stable(addr_q));

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_i |=> ph_q == '0);
endmodule

// File: rtl/scan_colour.sv
// Aligns the active flag with RAM read latency and picks the colour bits.
module scan_colour #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned RD_LAT = 1,
  parameter int unsigned R_BIT  = 2,
  parameter int unsigned G_BIT  = 1,
  parameter int unsigned B_BIT  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             red_o,
  output logic             green_o,
  output logic             blue_o
);
  logic act_al;

  generate
    if (RD_LAT == 0) begin : g_nolat
      assign act_al = active_i;
    end else begin : g_lat
      logic [RD_LAT-1:0] act_sr;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) act_sr <= '0;
        else if (RD_LAT == 1) act_sr <= active_i;
        else act_sr <= {act_sr[RD_LAT-2:0], active_i};
      end
      assign act_al = act_sr[RD_LAT-1];
    end
  endgenerate

  assign red_o   = act_al & pix_i[R_BIT];
  assign green_o = act_al & pix_i[G_BIT];
  assign blue_o  = act_al & pix_i[B_BIT];

  a_r8_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !(red_o || green_o || blue_o));
endmodule

// File: rtl/scanout_addr_gen.sv
module scanout_addr_gen
  import scan_pkg::*;
#(
  parameter int unsigned H_REP  = 4,
  parameter int unsigned RPT_W  = 8,
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned RD_LAT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              sof_i,
  input  logic              sol_i,
  input  logic [15:0]       start_addr_i,
  input  logic [15:0]       line_ofs_i,
  input  logic [RPT_W-1:0]  line_rpt_i,
  input  logic [PIX_W-1:0]  pix_byte_i,
  output logic [16:0]       rd_addr_o,
  output logic              red_o,
  output logic              green_o,
  output logic              blue_o
);
  vaddr_t load, addr;

  scan_vline #(.RPT_W(RPT_W)) i_vline (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sof_i  (sof_i),
    .sol_i  (sol_i),
    .start_i(start_addr_i),
    .ofs_i  (line_ofs_i),
    .rpt_i  (line_rpt_i),
    .load_o (load)
  );

  scan_hcount #(.H_REP(H_REP)) i_hcount (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active_i),
    .sol_i   (sol_i),
    .load_i  (load),
    .addr_o  (addr)
  );

  scan_colour #(.PIX_W(PIX_W), .RD_LAT(RD_LAT)) i_colour (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active_i),
    .pix_i   (pix_byte_i),
    .red_o   (red_o),
    .green_o (green_o),
    .blue_o  (blue_o)
  );

  assign rd_addr_o = addr;

  a_r7_joint_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && sol_i) |=> rd_addr_o == {1'b0, $past(start_addr_i)});
endmodule

// File: tb/test_scanout_addr_gen.sv
module test_scanout_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        active_i = 1'b0, sof_i = 1'b0, sol_i = 1'b0;
  logic [15:0] start_addr_i = '0, line_ofs_i = '0;
  logic [7:0]  line_rpt_i = '0, pix_byte_i = '0;
  logic [16:0] rd_addr_o;
  logic        red_o, green_o, blue_o;

  int n_tests = 0, n_fail = 0;
  string tag = "R2";
  longint m_start = 0, m_ofs = 0, m_rpt = 0, m_line = 0, m_k = 0;
  bit prev_a = 1'b0;

  always #10 clk_i = ~clk_i;

  scanout_addr_gen i_scanout_addr_gen (
    .clk_i, .rst_ni, .active_i, .sof_i, .sol_i, .start_addr_i, .line_ofs_i,
    .line_rpt_i, .pix_byte_i, .rd_addr_o, .red_o, .green_o, .blue_o
  );

  function automatic longint exp_addr(longint st, longint ofs, longint rpt,
                                      longint line, longint k);
    return (st + ((line - 1) / (rpt + 1)) * ofs + k / 4) & 64'h1FFFF;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit a, bit sf, bit sl);
    @(negedge clk_i);
    active_i = a; sof_i = sf; sol_i = sl; pix_byte_i = 8'($urandom);
    if (sf) begin
      m_start = start_addr_i; m_ofs = line_ofs_i; m_rpt = line_rpt_i; m_line = 0;
    end
    if (sl) begin m_line++; m_k = 0; end
    #1;
    chk("R8", {red_o, green_o, blue_o}, prev_a ? pix_byte_i[2:0] : 3'b000);
    if (a && !sl) begin
      chk(tag, rd_addr_o, exp_addr(m_start, m_ofs, m_rpt, m_line, m_k));
      m_k++;
    end
    prev_a = a;
  endtask

  task automatic line_body(int n_act, bit scramble);
    cyc(0, 0, 0);
    if (scramble) begin  // R6: mid-frame register writes
      start_addr_i = 16'($urandom); line_ofs_i = 16'($urandom);
      line_rpt_i = 8'($urandom_range(0, 5));
    end
    for (int i = 0; i < n_act; i++) cyc($urandom_range(0, 7) != 0, 0, 0);
    cyc(0, 0, 0);
  endtask

  task automatic frame(logic [15:0] st, logic [15:0] ofs, logic [7:0] rpt,
                       int lines, int n_act, bit joint, bit scramble);
    start_addr_i = st; line_ofs_i = ofs; line_rpt_i = rpt;
    if (joint) begin
      cyc(0, 1, 1);
      line_body(n_act, scramble);
    end else begin
      cyc(0, 1, 0);
      cyc(0, 0, 0);
      cyc(0, 0, 1);
      line_body(n_act, scramble);
    end
    for (int l = 1; l < lines; l++) begin
      cyc(0, 0, 1);
      line_body(n_act, scramble);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    pix_byte_i = 8'hFF;
    #1;
    chk("R1", rd_addr_o, 0);
    chk("R1", {red_o, green_o, blue_o}, 0);
    rst_ni = 1'b1;

    tag = "R3"; frame(16'h1234, 16'd320, 8'd3, 9, 24, 0, 0);
    tag = "R4"; frame(16'h0100, 16'd512, 8'd0, 6, 20, 0, 0);
    tag = "R5"; frame(16'hFFF0, 16'hFFFF, 8'd1, 7, 16, 0, 0);
    tag = "R9"; frame(16'h0040, 16'd100, 8'd2, 8, 7, 0, 0);
    // leave a frame partway through a repeat group, then restart jointly
    tag = "R7"; frame(16'h2000, 16'd64, 8'd3, 2, 12, 0, 0);
    frame(16'h5555, 16'd1000, 8'd2, 7, 14, 1, 0);
    tag = "R6";
    for (int f = 0; f < 6; f++)
      frame(16'($urandom), 16'($urandom), 8'($urandom_range(0, 4)),
            $urandom_range(4, 10), $urandom_range(5, 30), f[0], 1);
    tag = "R2";
    for (int f = 0; f < 4; f++)
      frame(16'($urandom), 16'($urandom_range(0, 2000)), 8'($urandom_range(0, 3)),
            $urandom_range(3, 9), $urandom_range(1, 40), 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule